// File: doc/BRIEF.md
# Bit-Serial CORDIC Rotator

This block rotates a two-component vector by a given angle with the CORDIC method in rotation mode. It uses one-bit arithmetic: each of the three lanes (X, Y and angle Z) has a single-bit adder/subtractor. That adder keeps its carry in a flip-flop from one bit to the next, so a full word is added across W clock cycles. The X, Y and Z words are held in shift registers. Each iteration streams them through the adders least significant bit first. The new bits enter at the top, so after W clocks each register holds the updated value. The design gives up latency to save area.

A controller moves through four states: idle, operand load, a one-clock setup at the start of each iteration, and compute. In the setup clock the rotation direction is read from the sign of Z and held for the rest of the word. The arithmetically shifted copies of X and Y and the arctangent constant are also captured into snapshot shift registers in that clock, so the in-place updates cannot corrupt them. The result has no gain compensation. The caller pre-scales the inputs if an exact magnitude is wanted.

`start_i` and `done_o` are plain control and status pins, not a stream handshake. There is no back-pressure. Operands are read once, in the clock after start is accepted, and the results stay on the outputs until the next start.

Top module: `bit_serial_cordic`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done_o` is 0 and `x_o`, `y_o` and `z_o` are all zero. A reset in the middle of a run abandons that run.
- R2: Let edge 0 be the clock edge that samples `start_i` high in idle. `done_o` rises at edge W*ITERS+1, which is 993 with the defaults, and not before.
- R3: The operands `x0_i`, `y0_i` and `z0_i` are sampled only at edge 1, the load clock after start is accepted. Their values at edge 0 and from edge 2 onward have no effect on the result.
- R4: For each iteration i = 0 .. ITERS-1, let the direction be positive when bit W-1 of Z is 0. A positive step computes X' = X - (Y>>>i), Y' = Y + (X>>>i) and Z' = Z - A(i). A negative step uses the opposite signs. All values are W-bit two's complement, the shift is arithmetic, and sums wrap modulo 2^W.
- R5: The direction for an iteration is fixed by Z as it stands in that iteration's first clock, and it is held for all W bit clocks of the word.
- R6: A(i) equals round(atan(2^-i) * 2^FRAC), a non-negative constant with FRAC fractional bits (Q4.28 with the defaults).
- R7: A start pulse during a run is ignored. The run keeps its latency and its result.
- R8: After completion, `done_o` stays 1 and the outputs keep their values until a start is accepted. `done_o` is 0 from the edge after that start.
- R9: With x0 = 0.6072529*2^FRAC, y0 = 0 and z0 = (pi/6)*2^FRAC, `x_o` and `y_o` are within 2^-16 of cos(pi/6) and sin(pi/6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a rotation when the block is idle |
| x0_i | input | W | Initial X, two's complement fixed point |
| y0_i | input | W | Initial Y, two's complement fixed point |
| z0_i | input | W | Rotation angle in radians, fixed point |
| x_o | output | W | Rotated X (X register contents) |
| y_o | output | W | Rotated Y (Y register contents) |
| z_o | output | W | Residual angle (Z register contents) |
| done_o | output | 1 | High when a run has finished and the results are valid |

## Verification
The hardest case to reach is a direction or carry state that is kept across bit clocks. An error there only shows when a carry or a sign-extended shifted bit crosses many bit positions within one word. Vectors near full scale, negative angles and a near-pi/2 rotation drive long carry and borrow chains and use shifted operands whose upper bits are pure sign extension. Extra start pulses and operand changes are placed inside the busy window, at its first two edges and in the middle of the run, to expose any late sampling.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRELOAD,
    ST_SETUP,
    ST_COMPUTE
  } cs_state_e;
endpackage

// File: rtl/cs_serial_addsub.sv
module cs_serial_addsub (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic first_i,
  input  logic sub_i,
  input  logic a_i,
  input  logic b_i,
  output logic s_o
);
  logic carry_q;
  logic cin;
  logic bx;

  // Seed the carry with 1 on a subtract so that inverting b gives a two's-complement negate.
  assign cin = first_i ? sub_i : carry_q;
  assign bx  = b_i ^ sub_i;
  assign s_o = a_i ^ bx ^ cin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= 1'b0;
    else if (en_i) carry_q <= (a_i & bx) | (a_i & cin) | (bx & cin);
  end

  // R5
  sub_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !first_i) |-> $stable(sub_i));
endmodule

// File: rtl/cs_atan_rom.sv
module cs_atan_rom #(
  parameter int W     = 32,
  parameter int FRAC  = 28,
  parameter int ITERS = 31,
  parameter int IW    = 5
) (
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  atan_o
);
  localparam int DEPTH = 1 << IW;

  function automatic logic [W-1:0] atan_fx(input int i);
    real r;
    r = $atan(2.0 ** (-i)) * (2.0 ** FRAC);
    return W'($rtoi(r + 0.5));
  endfunction

  logic [W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < ITERS) begin : g_used
      assign tbl[g] = atan_fx(g);
    end else begin : g_pad
      assign tbl[g] = '0;
    end
  end

  assign atan_o = tbl[idx_i];
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cordic_pkg::*;
#(
  parameter int W     = 32,
  parameter int ITERS = 31,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output cs_state_e     state_o,
  output logic [IW-1:0] iter_o,
  output logic          done_o
);
  localparam int BW = $clog2(W);

  logic [BW-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= ST_IDLE;
      iter_o  <= '0;
      bit_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      case (state_o)
        ST_IDLE: if (start_i) begin
          state_o <= ST_PRELOAD;
          done_o  <= 1'b0;
        end
        ST_PRELOAD: begin
          state_o <= ST_SETUP;
          iter_o  <= '0;
        end
        ST_SETUP: begin
          state_o <= ST_COMPUTE;
          bit_q   <= BW'(1);
        end
        default: begin
          if (bit_q == BW'(W - 1)) begin
            bit_q <= '0;
            if (iter_o == IW'(ITERS - 1)) begin
              state_o <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              iter_o  <= iter_o + 1'b1;
              state_o <= ST_SETUP;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SETUP) |=> (state_o == ST_COMPUTE));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != ST_IDLE && start_i) |=> (state_o != ST_PRELOAD));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_o == ST_IDLE));
endmodule

// File: rtl/bit_serial_cordic.sv
module bit_serial_cordic
  import cordic_pkg::*;
#(
  parameter int W     = 32,
  parameter int FRAC  = 28,
  parameter int ITERS = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] x0_i,
  input  logic [W-1:0] y0_i,
  input  logic [W-1:0] z0_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] z_o,
  output logic         done_o
);
  localparam int IW  = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam int LAT = W * ITERS + 1;

  cs_state_e     state;
  logic [IW-1:0] iter;
  logic [W-1:0]  atan_now;

  cs_ctrl #(.W(W), .ITERS(ITERS), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .state_o(state), .iter_o(iter), .done_o(done_o)
  );

  cs_atan_rom #(.W(W), .FRAC(FRAC), .ITERS(ITERS), .IW(IW)) u_rom (
    .idx_i(iter), .atan_o(atan_now)
  );

  logic signed [W-1:0] x_sr, y_sr, z_sr;
  logic signed [W-1:0] xs_q, ys_q;
  logic [W-1:0]        at_q;
  logic                dir_q;
  logic signed [W-1:0] xs_full, ys_full;
  logic                setup, step, neg;
  logic                xs_bit, ys_bit, at_bit;
  logic [2:0]          a_l, b_l, sub_l, s_l;

  assign setup   = (state == ST_SETUP);
  assign step    = setup || (state == ST_COMPUTE);
  assign xs_full = x_sr >>> iter;
  assign ys_full = y_sr >>> iter;
  assign neg     = setup ? z_sr[W-1] : dir_q;
  assign xs_bit  = setup ? xs_full[0] : xs_q[0];
  assign ys_bit  = setup ? ys_full[0] : ys_q[0];
  assign at_bit  = setup ? atan_now[0] : at_q[0];

  // lane 0 = X, lane 1 = Y, lane 2 = Z
  assign a_l   = {z_sr[0], y_sr[0], x_sr[0]};
  assign b_l   = {at_bit, xs_bit, ys_bit};
  assign sub_l = {~neg, neg, ~neg};

  for (genvar l = 0; l < 3; l++) begin : g_lane
    cs_serial_addsub u_as (
      .clk(clk), .rst_n(rst_n), .en_i(step), .first_i(setup),
      .sub_i(sub_l[l]), .a_i(a_l[l]), .b_i(b_l[l]), .s_o(s_l[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sr  <= '0;
      y_sr  <= '0;
      z_sr  <= '0;
      xs_q  <= '0;
      ys_q  <= '0;
      at_q  <= '0;
      dir_q <= 1'b0;
    end else if (state == ST_PRELOAD) begin
      x_sr <= x0_i;
      y_sr <= y0_i;
      z_sr <= z0_i;
    end else if (step) begin
      x_sr <= {s_l[0], x_sr[W-1:1]};
      y_sr <= {s_l[1], y_sr[W-1:1]};
      z_sr <= {s_l[2], z_sr[W-1:1]};
      if (setup) begin
        dir_q <= z_sr[W-1];
        xs_q  <= xs_full >>> 1;
        ys_q  <= ys_full >>> 1;
        at_q  <= atan_now >> 1;
      end else begin
        xs_q <= xs_q >>> 1;
        ys_q <= ys_q >>> 1;
        at_q <= at_q >> 1;
      end
    end
  end

  assign x_o = x_sr;
  assign y_o = y_sr;
  assign z_o = z_sr;

  logic [31:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lat_q <= '0;
    else if (state == ST_IDLE && start_i)  lat_q <= '0;
    else if (state != ST_IDLE)             lat_q <= lat_q + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (lat_q == 32'(LAT)));

  // R3
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRELOAD) |=> (x_sr == $past(x0_i) && y_sr == $past(y0_i) && z_sr == $past(z0_i)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(x_sr) && $stable(y_sr) && $stable(z_sr)));
endmodule

// File: tb/test_bit_serial_cordic.sv
module test_bit_serial_cordic;
  localparam int W     = 32;
  localparam int FRAC  = 28;
  localparam int ITERS = 31;
  localparam int LAT   = W * ITERS + 1;
  localparam int NV    = 6;

  // {x0, y0, z0}
  localparam logic [3*W-1:0] VEC [NV] = '{
    {32'h1000_0000, 32'h0000_0000, 32'h0860_0000},
    {32'h0800_0000, 32'h0400_0000, 32'hF200_0000},
    {32'h0100_0000, 32'hFF00_0000, 32'h0000_0000},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h1000_0000},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h8000_0000, 32'h0000_0000, 32'h1921_FB54}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] x0 = '0, y0 = '0, z0 = '0;
  logic [W-1:0] xo, yo, zo;
  logic done;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bit_serial_cordic #(.W(W), .FRAC(FRAC), .ITERS(ITERS)) i_bit_serial_cordic (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .x0_i(x0), .y0_i(y0), .z0_i(z0),
    .x_o(xo), .y_o(yo), .z_o(zo), .done_o(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] atan_ref(input int i);
    return W'($rtoi($atan(2.0 ** (-i)) * (2.0 ** FRAC) + 0.5));
  endfunction

  task automatic model(input logic [W-1:0] xi, input logic [W-1:0] yi, input logic [W-1:0] zi,
                       output logic [W-1:0] xe, output logic [W-1:0] ye, output logic [W-1:0] ze);
    logic signed [W-1:0] x, y, z, dx, dy;
    x = xi; y = yi; z = zi;
    for (int i = 0; i < ITERS; i++) begin
      dx = x >>> i;
      dy = y >>> i;
      if (!z[W-1]) begin
        x = x - dy; y = y + dx; z = z - atan_ref(i);
      end else begin
        x = x + dy; y = y - dx; z = z + atan_ref(i);
      end
    end
    xe = x; ye = y; ze = z;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < LAT + 50) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
  endtask

  task automatic run(input logic [W-1:0] xi, input logic [W-1:0] yi, input logic [W-1:0] zi,
                     output int cyc);
    @(negedge clk);
    x0 = xi; y0 = yi; z0 = zi; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] xe, ye, ze, xh, yh, zh;
    int cyc;
    real kq, ang;
    logic signed [W-1:0] cexp, sexp;

    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 done", {31'b0, done}, '0);
    check("R1 x", xo, '0);
    check("R1 y", yo, '0);
    check("R1 z", zo, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", {31'b0, done}, '0);

    // R4, R5, R6, R2: table walk
    for (int v = 0; v < NV; v++) begin
      run(VEC[v][3*W-1:2*W], VEC[v][2*W-1:W], VEC[v][W-1:0], cyc);
      model(VEC[v][3*W-1:2*W], VEC[v][2*W-1:W], VEC[v][W-1:0], xe, ye, ze);
      check("R2 latency", W'(cyc), W'(LAT));
      check("R4,R5,R6 x", xo, xe);
      check("R4,R5,R6 y", yo, ye);
      check("R4,R5,R6 z", zo, ze);
    end

    // R8: results and done hold while idle
    xh = xo; yh = yo; zh = zo;
    x0 = 32'h1234_5678; y0 = 32'h0BAD_0BAD; z0 = 32'h0111_0000;
    repeat (25) @(negedge clk);
    check("R8 done held", {31'b0, done}, 32'd1);
    check("R8 x held", xo, xh);
    check("R8 y held", yo, yh);
    check("R8 z held", zo, zh);

    // R3: only the load-clock operands matter
    @(negedge clk);
    x0 = 32'h0FFF_0000; y0 = 32'h0FFF_0000; z0 = 32'hF000_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R8 done clears after start", {31'b0, done}, '0);
    x0 = 32'h0300_0000; y0 = 32'hFD00_0000; z0 = 32'h0400_0000;
    @(posedge clk);
    @(negedge clk);
    x0 = 32'h7000_0000; y0 = 32'h7000_0000; z0 = 32'h7000_0000;
    cyc = 1;
    while (!done && cyc < LAT + 50) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    model(32'h0300_0000, 32'hFD00_0000, 32'h0400_0000, xe, ye, ze);
    check("R3 x", xo, xe);
    check("R3 y", yo, ye);
    check("R3 z", zo, ze);

    // R7: start pulse while busy is ignored
    @(negedge clk);
    x0 = 32'h0800_0000; y0 = 32'h0200_0000; z0 = 32'h0A00_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    x0 = 32'h0100_0000; y0 = 32'h0100_0000; z0 = 32'hF000_0000; start = 1'b1;
    @(posedge clk); cyc++; @(negedge clk);
    start = 1'b0;
    while (!done && cyc < LAT + 50) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    model(32'h0800_0000, 32'h0200_0000, 32'h0A00_0000, xe, ye, ze);
    check("R7 latency", W'(cyc), W'(LAT));
    check("R7 x", xo, xe);
    check("R7 y", yo, ye);
    check("R7 z", zo, ze);

    // R9: pre-scaled unit vector rotated by pi/6
    kq  = 0.6072529350088813 * (2.0 ** FRAC);
    ang = 0.5235987755982988;
    run(W'($rtoi(kq + 0.5)), '0, W'($rtoi(ang * (2.0 ** FRAC) + 0.5)), cyc);
    cexp = W'($rtoi($cos(ang) * (2.0 ** FRAC) + 0.5));
    sexp = W'($rtoi($sin(ang) * (2.0 ** FRAC) + 0.5));
    n_chk++;
    if ($signed(xo) - cexp > 4096 || cexp - $signed(xo) > 4096) begin
      n_bad++;
      $display("FAIL R9 cos actual=%h expected=%h", xo, cexp);
    end
    n_chk++;
    if ($signed(yo) - sexp > 4096 || sexp - $signed(yo) > 4096) begin
      n_bad++;
      $display("FAIL R9 sin actual=%h expected=%h", yo, sexp);
    end

    // R1: reset in mid-run abandons it
    @(negedge clk);
    x0 = 32'h0500_0000; y0 = 32'h0500_0000; z0 = 32'h0200_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run done", {31'b0, done}, '0);
    check("R1 mid-run x", xo, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 stays idle", {31'b0, done}, '0);
    run(VEC[1][3*W-1:2*W], VEC[1][2*W-1:W], VEC[1][W-1:0], cyc);
    model(VEC[1][3*W-1:2*W], VEC[1][2*W-1:W], VEC[1][W-1:0], xe, ye, ze);
    check("R2 latency after reset", W'(cyc), W'(LAT));
    check("R4 x after reset", xo, xe);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule